// File: doc/BRIEF.md
# Peak-Hold Gate and Dead-Time Sequencer

This block runs one acquisition cycle of a single-channel pulse-height analyzer. It picks a gate from one of two sources. In self-triggered mode the gate is the discriminator's above-threshold level. In external mode the gate is a gate signal from outside. While the gate is open the peak stretcher tracks the input. When the gate closes, the block decides whether the event is acceptable. An accepted event makes the block hold the stretcher, strobe the ADC, wait for the ADC's ready handshake and pass the converted code on with a one-cycle valid pulse. The block then stays busy until a fixed dead time has passed.

In external mode a peak-detected indication is needed, and the gate must stay open for a minimum number of cycles after it. If either condition fails, the event is dropped without a conversion and a reject counter advances. A 7-bit threshold code for the discriminator DAC is stored here and limited to the 100 legal steps. All timing figures are parameters in clock cycles (defaults: 10-cycle post-peak extension and 240-cycle dead time, matching 0.2 µs and 4.8 µs at 50 MHz).

Top module: `peak_gate_seq`

## Requirements
- R1: After a synchronous active-high reset, busy, hold, adc_start and sample_valid are 0, rej_cnt is 0 and thr_code is 0.
- R2: With mode_ext=0 the gate is disc_above. An idle block opens on gate high. In the first cycle after the cycle in which the gate is sampled low, busy, hold and adc_start are all 1, whether or not peak_det was seen.
- R3: With mode_ext=0, ext_gate has no effect. With mode_ext=1, disc_above has no effect, and the gate is ext_gate. The mode is sampled when the gate opens.
- R4: With mode_ext=1, an event is accepted only if peak_det was sampled high while the gate was open and the gate then stayed high for at least MIN_EXT further cycles. Otherwise no adc_start is issued, busy stays 0 and rej_cnt rises by exactly 1 in the cycle after the gate closes.
- R5: adc_start is a single-cycle pulse in the first busy cycle. hold is 1 from that cycle through the cycle in which adc_ready is sampled high, and 0 afterwards.
- R6: busy stays high for exactly DEAD_CYC consecutive cycles per accepted event, provided adc_ready arrives within that window.
- R7: Gate activity on either input while busy is 1 is ignored. It starts no new event and does not change rej_cnt.
- R8: sample_valid is high for one cycle, in the cycle after adc_ready is sampled high during conversion, with sample_data equal to adc_data from that cycle. adc_ready outside conversion produces no sample_valid.
- R9: A write via thr_we stores thr_wdata into thr_code, visible the next cycle, clamped to 99 for values above 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ext | input | 1 | 0: gate from discriminator, 1: external gate |
| disc_above | input | 1 | Discriminator above-threshold level |
| ext_gate | input | 1 | External gate level |
| peak_det | input | 1 | Stretcher peak-detected indication |
| adc_ready | input | 1 | ADC conversion done |
| adc_data | input | DW | ADC result |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 7 | Threshold code to write |
| hold | output | 1 | Peak stretcher hold (0 = track/released) |
| adc_start | output | 1 | ADC start strobe |
| busy | output | 1 | Dead-time flag |
| sample_valid | output | 1 | Accepted sample valid pulse |
| sample_data | output | DW | Accepted sample code |
| thr_code | output | 7 | Stored discriminator threshold, 0..99 |
| rej_cnt | output | RW | Count of rejected events |

## Verification
A corrupted state register or dead-time counter shows up at the end of the event as a busy window of the wrong length. It can also show up as a start strobe lasting more than one cycle, or as hold released before the ADC handshake. All of these are visible within one dead-time interval. A wrong post-peak counter shows up one cycle after the gate closes: an accepted event appears where a reject count was due, or the reverse. The sweep covers every extension length around the limit in both modes.

// File: rtl/peak_gate_seq.sv
module peak_gate_seq #(
  parameter int DW       = 13,
  parameter int MIN_EXT  = 10,
  parameter int DEAD_CYC = 240,
  parameter int RW       = 16,
  parameter int THR_MAX  = 99
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_ext,
  input  logic          disc_above,
  input  logic          ext_gate,
  input  logic          peak_det,
  input  logic          adc_ready,
  input  logic [DW-1:0] adc_data,
  input  logic          thr_we,
  input  logic [6:0]    thr_wdata,
  output logic          hold,
  output logic          adc_start,
  output logic          busy,
  output logic          sample_valid,
  output logic [DW-1:0] sample_data,
  output logic [6:0]    thr_code,
  output logic [RW-1:0] rej_cnt
);
  localparam int EW = $clog2(MIN_EXT + 1);
  localparam int CW = $clog2(DEAD_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_GATED, S_CONV, S_DEAD} st_t;

  st_t           st;
  logic          mode_q, pk;
  logic [EW-1:0] ecnt;
  logic [CW-1:0] dcnt;
  logic          gate_now, close_ok, dead_done;

  assign gate_now  = ((st == S_IDLE) ? mode_ext : mode_q) ? ext_gate : disc_above;
  assign close_ok  = !mode_q || (pk && ecnt >= EW'(MIN_EXT));
  assign dead_done = dcnt == CW'(DEAD_CYC - 1);

  assign hold      = st == S_CONV;
  assign busy      = (st == S_CONV) || (st == S_DEAD);
  assign adc_start = (st == S_CONV) && (dcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      mode_q       <= 1'b0;
      pk           <= 1'b0;
      ecnt         <= '0;
      dcnt         <= '0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      rej_cnt      <= '0;
      thr_code     <= '0;
    end else begin
      sample_valid <= 1'b0;
      if (thr_we)
        thr_code <= (thr_wdata > 7'(THR_MAX)) ? 7'(THR_MAX) : thr_wdata;
      case (st)
        S_IDLE: if (gate_now) begin
          st     <= S_GATED;
          mode_q <= mode_ext;
          pk     <= 1'b0;
          ecnt   <= '0;
        end
        S_GATED: begin
          if (!gate_now) begin
            dcnt <= '0;
            if (close_ok) st <= S_CONV;
            else begin
              st      <= S_IDLE;
              rej_cnt <= rej_cnt + 1'b1;
            end
          end else if (peak_det) begin
            pk   <= 1'b1;
            ecnt <= '0;
          end else if (pk && ecnt < EW'(MIN_EXT)) begin
            ecnt <= ecnt + 1'b1;
          end
        end
        S_CONV: begin
          if (!dead_done) dcnt <= dcnt + 1'b1;
          if (adc_ready) begin
            sample_valid <= 1'b1;
            sample_data  <= adc_data;
            st           <= dead_done ? S_IDLE : S_DEAD;
          end
        end
        S_DEAD: begin
          if (dead_done) st <= S_IDLE;
          else dcnt <= dcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/peak_gate_seq_chk.sv
module peak_gate_seq_chk #(
  parameter int DEAD_CYC = 240,
  parameter int RW       = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          hold,
  input logic          adc_start,
  input logic          busy,
  input logic          sample_valid,
  input logic [6:0]    thr_code,
  input logic [RW-1:0] rej_cnt
);
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst) adc_start |=> !adc_start); // R5
  AST_START_HOLD:  assert property (@(posedge clk) disable iff (rst) adc_start |-> hold && busy); // R5
  AST_HOLD_BUSY:   assert property (@(posedge clk) disable iff (rst) hold |-> busy); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) sample_valid |=> !sample_valid); // R8
  AST_DEAD_LEN:    assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> run >= 16'(DEAD_CYC)); // R6
  AST_BUSY_NOREJ:  assert property (@(posedge clk) disable iff (rst) busy |=> $stable(rej_cnt)); // R7
  AST_THR_RANGE:   assert property (@(posedge clk) disable iff (rst) thr_code <= 7'd99); // R9
endmodule

bind peak_gate_seq peak_gate_seq_chk #(.DEAD_CYC(DEAD_CYC), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .adc_start(adc_start), .busy(busy),
  .sample_valid(sample_valid), .thr_code(thr_code), .rej_cnt(rej_cnt)
);

// File: tb/peak_gate_seq_bench.sv
module peak_gate_seq_bench;
  localparam int DW = 13, MIN_EXT = 3, DEAD_CYC = 12, RW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_ext = 0, disc_above = 0, ext_gate = 0, peak_det = 0, adc_ready = 0, thr_we = 0;
  logic [DW-1:0] adc_data = '0;
  logic [6:0]    thr_wdata = '0;
  logic hold, adc_start, busy, sample_valid;
  logic [DW-1:0] sample_data;
  logic [6:0]    thr_code;
  logic [RW-1:0] rej_cnt;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  peak_gate_seq #(.DW(DW), .MIN_EXT(MIN_EXT), .DEAD_CYC(DEAD_CYC), .RW(RW)) u_peak_gate_seq (
    .clk(clk), .rst(rst), .mode_ext(mode_ext), .disc_above(disc_above), .ext_gate(ext_gate),
    .peak_det(peak_det), .adc_ready(adc_ready), .adc_data(adc_data), .thr_we(thr_we),
    .thr_wdata(thr_wdata), .hold(hold), .adc_start(adc_start), .busy(busy),
    .sample_valid(sample_valid), .sample_data(sample_data), .thr_code(thr_code), .rej_cnt(rej_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic set_gate(input bit v);
    if (mode_ext) ext_gate = v; else disc_above = v;
  endtask

  // n < 0: no peak_det pulse; otherwise gate stays n cycles after the peak cycle
  task automatic run_event(input bit ext, input int n, input int d, input logic [DW-1:0] val);
    int rej0;
    bit acc;
    int bcnt;
    mode_ext = ext;
    // R3: the unselected gate input must do nothing
    if (ext) disc_above = 1; else ext_gate = 1;
    repeat (3) begin
      @(negedge clk);
      chk(busy == 0 && adc_start == 0, "R3 unselected gate", busy, 0);
    end
    disc_above = 0; ext_gate = 0;
    @(negedge clk);
    rej0 = rej_cnt;
    set_gate(1);
    @(negedge clk);
    if (n >= 0) begin
      peak_det = 1;
      @(negedge clk);
      peak_det = 0;
      repeat (n) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
    end
    set_gate(0);
    acc = !ext || (n >= MIN_EXT);
    @(negedge clk);
    if (!acc) begin
      chk(busy == 0 && adc_start == 0, "R4 reject no start", adc_start, 0);
      chk(rej_cnt == RW'(rej0 + 1), "R4 reject count", rej_cnt, rej0 + 1);
      @(negedge clk);
      chk(busy == 0, "R4 stays idle", busy, 0);
      return;
    end
    chk(rej_cnt == RW'(rej0), "R2 no reject on accept", rej_cnt, rej0);
    bcnt = 0;
    for (int k = 0; k < 400; k++) begin
      if (!busy) break;
      bcnt++;
      if (k == 0) chk(hold == 1 && adc_start == 1, "R2 start on close", adc_start, 1);
      else chk(adc_start == 0, "R5 start single pulse", adc_start, 0);
      chk(hold == (k <= d), "R5 hold window", hold, int'(k <= d));
      chk(sample_valid == (k == d + 1), "R8 valid timing", sample_valid, int'(k == d + 1));
      if (k == d + 1) chk(sample_data == val, "R8 sample data", sample_data, val);
      adc_ready = (k == d);
      adc_data  = (k == d) ? val : ~val;
      if (k == 3) begin disc_above = 1; ext_gate = 1; end // R7 noise while busy
      if (k == DEAD_CYC - 3) begin disc_above = 0; ext_gate = 0; end
      @(negedge clk);
    end
    adc_ready = 0;
    chk(bcnt == DEAD_CYC, "R6 dead time length", bcnt, DEAD_CYC);
    chk(rej_cnt == RW'(rej0), "R7 noise no reject", rej_cnt, rej0);
    @(negedge clk);
    chk(busy == 0 && adc_start == 0, "R7 no event from noise", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && hold == 0 && adc_start == 0 && sample_valid == 0, "R1 reset outputs", busy, 0);
    chk(rej_cnt == 0 && thr_code == 0, "R1 reset registers", rej_cnt, 0);
    rst = 0;
    @(negedge clk);
    // R8: ready outside conversion
    adc_ready = 1; adc_data = 13'h155;
    @(negedge clk);
    adc_ready = 0;
    chk(sample_valid == 0, "R8 stray ready ignored", sample_valid, 0);
    // R9: threshold sweep
    for (int v = 0; v < 128; v++) begin
      thr_we = 1; thr_wdata = 7'(v);
      @(negedge clk);
      thr_we = 0;
      chk(thr_code == 7'((v > 99) ? 99 : v), "R9 threshold clamp", thr_code, (v > 99) ? 99 : v);
    end
    // R2 R3 R4 R5 R6 R7 R8: mode x extension x ready delay
    for (int m = 0; m < 2; m++)
      for (int n = -1; n <= MIN_EXT + 2; n++)
        for (int d = 0; d < 6; d += 2)
          run_event(m[0], n, d, DW'(m * 1000 + (n + 1) * 97 + d * 13 + 8000));
    finish_run();
  end
endmodule